// File: doc/BRIEF.md
# Configurable Parallel-to-Serial Output Gearbox

This block converts 8-bit parallel words into a fast double-data-rate serial stream. It runs on the fast clock only. The slow word rate follows from a slot timer inside the stage-three shifter, and that timer paces a valid/ready input port. Each fast cycle sends a pair of bits on a lane: the bit on the rising-edge output goes first, then the bit on the falling-edge output. Bits leave least significant first.

A mode input, sampled only while reset is held, selects one of three formats. The first is one 8:1 lane, with one word every 4 fast cycles. The second is a 7:1 lane for video-style links: it sends bits 6..0 and alternates 4-cycle and 3-cycle word slots, carrying the odd half-pair over in a residual bit. The third is two independent 4:1 lanes, with one word every 2 fast cycles.

Data passes through three stages: a capture register, a transfer register, and a shift/multiplex stage that drives registered outputs.

Back-pressure rules: a word is accepted on a clock edge where `d_valid` and `d_ready` are both high. `d_ready` does not depend on `d_valid`. While `d_ready` is low, the source must hold its word. The output never stalls. If no word is waiting when a lane runs dry, that lane sends zero bits.

Top module: `gbx_serializer`

## Requirements
- R1: While reset is held and after it is released, and until the first accepted word reaches stage three, all four serial outputs are 0 and `d_ready` is 1.
- R2: In mode 2'b00 (8:1), lane A sends the 8 bits of each word LSB first, two per cycle (the lower-index bit on `q_a_rise`). The stream has no gap between words while the source keeps `d_valid` high.
- R3: In mode 2'b01 (7:1), lane A sends only bits 6..0 of each word, LSB first, back to back. Bit 7 has no effect on any output.
- R4: In mode 2'b10 (dual 4:1), lane A sends bits 3..0 and lane B sends bits 7..4 of each word. Each lane runs LSB first, two bits per cycle, with one word every 2 cycles.
- R5: In modes other than 2'b10, `q_b_rise` and `q_b_fall` stay 0. Mode 2'b11 behaves as 2'b00.
- R6: A word accepted on clock edge E first appears on the outputs after edge E+2.
- R7: When the capture stage holds a word that cannot move on, `d_ready` is 0 and that word is kept. Every accepted word is sent exactly once, in order.
- R8: When a lane runs out of words, it finishes any residual bit and then sends zeros.
- R9: The mode input is sampled only during reset. Changing it while running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial clock |
| rst | input | 1 | Synchronous reset, active high; samples `mode` |
| mode | input | 2 | Format: 00 8:1, 01 7:1, 10 dual 4:1, 11 as 00 |
| d_valid | input | 1 | Parallel word offered |
| d_ready | output | 1 | Capture stage can accept a word this edge |
| d | input | 8 | Parallel word |
| q_a_rise | output | 1 | Lane A, first bit of the pair |
| q_a_fall | output | 1 | Lane A, second bit of the pair |
| q_b_rise | output | 1 | Lane B, first bit of the pair (dual mode only) |
| q_b_fall | output | 1 | Lane B, second bit of the pair (dual mode only) |

## Verification
Each mode receives a burst of distinct words with the source always valid. This shows that bit order, the rise/fall pairing and the slot lengths are right, and that words join with no gap. The 7:1 burst sets bit 7 in every word, so a leak of that bit would show up as a wrong bit. Its odd word length also exercises the residual carry across the alternating 4/3 slots. The dual-mode burst uses different nibbles in each half, which separates the two lanes. A change of the mode pin in the middle of an 8:1 burst, plus a drain to idle after each burst, covers the reset-only mode sampling and the zero fill.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
  typedef enum logic [1:0] {
    FMT_8TO1 = 2'b00,
    FMT_7TO1 = 2'b01,
    FMT_DUAL4 = 2'b10,
    FMT_ALT8 = 2'b11
  } fmt_e;

  localparam int unsigned WORD_W = 8;
  localparam int unsigned CNT_W  = 4;
endpackage

// File: rtl/gbx_capture.sv
module gbx_capture #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_word,
  input  logic         xfer,
  output logic         in_ready,
  output logic         s1_valid,
  output logic [W-1:0] s1_word
);
  assign in_ready = !s1_valid || xfer;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_word  <= '0;
    end else if (in_valid && in_ready) begin
      s1_valid <= 1'b1;
      s1_word  <= in_word;
    end else if (xfer) begin
      s1_valid <= 1'b0;
    end
  end

  // R7: a blocked word is kept unchanged
  p_hold_word_r7: assert property (@(posedge clk) disable iff (rst)
    s1_valid && !xfer |=> s1_valid && $stable(s1_word));
endmodule

// File: rtl/gbx_transfer.sv
module gbx_transfer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         s1_valid,
  input  logic [W-1:0] s1_word,
  input  logic         take,
  output logic         xfer,
  output logic         s2_valid,
  output logic [W-1:0] s2_word
);
  assign xfer = s1_valid && (!s2_valid || take);

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_word  <= '0;
    end else if (xfer) begin
      s2_valid <= 1'b1;
      s2_word  <= s1_word;
    end else if (take) begin
      s2_valid <= 1'b0;
    end
  end

  // R6: a moved word is present in stage two on the next edge
  p_xfer_lands_r6: assert property (@(posedge clk) disable iff (rst)
    xfer |=> s2_valid);
endmodule

// File: rtl/gbx_lane.sv
module gbx_lane #(
  parameter int unsigned WMAX = 8,
  parameter int unsigned CW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic [WMAX-1:0] word,
  input  logic [CW-1:0]   word_len,
  output logic            need,
  output logic            q_rise,
  output logic            q_fall
);
  localparam int unsigned SHW = WMAX + 1;

  logic [SHW-1:0] sh, ext;
  logic [CW-1:0]  n, tot;

  assign need = (n < CW'(2));

  always_comb begin
    ext = sh;
    tot = n;
    if (take) begin
      ext = sh | (SHW'(word) << n);
      tot = n + word_len;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      n      <= '0;
      q_rise <= 1'b0;
      q_fall <= 1'b0;
    end else begin
      q_rise <= ext[0];
      q_fall <= ext[1];
      sh     <= ext >> 2;
      n      <= (tot >= CW'(2)) ? tot - CW'(2) : '0;
    end
  end

  always_comb begin
    if (!rst) begin
      p_count_bound_r2: assert (n <= CW'(WMAX - 1))
        else $error("lane bit count out of range");
    end
  end

  // R2: without a new word, two bits drain per cycle
  p_drain_r2: assert property (@(posedge clk) disable iff (rst)
    !take && n >= CW'(2) |=> n == $past(n) - CW'(2));
endmodule

// File: rtl/gbx_serializer.sv
module gbx_serializer
  import gbx_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode,
  input  logic         d_valid,
  output logic         d_ready,
  input  logic [W-1:0] d,
  output logic         q_a_rise,
  output logic         q_a_fall,
  output logic         q_b_rise,
  output logic         q_b_fall
);
  localparam int unsigned HALF = W / 2;

  fmt_e           fmt_q;
  logic           s1_valid, s2_valid, xfer, take, take_b, need_a, need_b;
  logic [W-1:0]   s1_word, s2_word, word_a, word_b;
  logic [CW-1:0]  len_a, len_b;

  always_ff @(posedge clk) begin
    if (rst) fmt_q <= fmt_e'(mode);
  end

  assign take   = need_a && s2_valid;
  assign take_b = take && (fmt_q == FMT_DUAL4);

  always_comb begin
    word_b = W'(s2_word[W-1:HALF]);
    len_b  = CW'(HALF);
    unique case (fmt_q)
      FMT_7TO1: begin
        word_a = {1'b0, s2_word[W-2:0]};
        len_a  = CW'(W - 1);
      end
      FMT_DUAL4: begin
        word_a = W'(s2_word[HALF-1:0]);
        len_a  = CW'(HALF);
      end
      default: begin
        word_a = s2_word;
        len_a  = CW'(W);
      end
    endcase
  end

  gbx_capture #(.W(W)) u_cap (
    .clk(clk), .rst(rst), .in_valid(d_valid), .in_word(d), .xfer(xfer),
    .in_ready(d_ready), .s1_valid(s1_valid), .s1_word(s1_word)
  );

  gbx_transfer #(.W(W)) u_xfr (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_word(s1_word),
    .take(take), .xfer(xfer), .s2_valid(s2_valid), .s2_word(s2_word)
  );

  gbx_lane #(.WMAX(W), .CW(CW)) u_lane_a (
    .clk(clk), .rst(rst), .take(take), .word(word_a), .word_len(len_a),
    .need(need_a), .q_rise(q_a_rise), .q_fall(q_a_fall)
  );

  gbx_lane #(.WMAX(W), .CW(CW)) u_lane_b (
    .clk(clk), .rst(rst), .take(take_b), .word(word_b), .word_len(len_b),
    .need(need_b), .q_rise(q_b_rise), .q_fall(q_b_fall)
  );

  // R1: reset forces all serial outputs low
  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> !q_a_rise && !q_a_fall && !q_b_rise && !q_b_fall);

  // R5: lane B stays idle outside dual mode
  p_lane_b_idle_r5: assert property (@(posedge clk) disable iff (rst)
    fmt_q != FMT_DUAL4 |=> !q_b_rise && !q_b_fall);

  // R4: both lanes stay in step in dual mode
  p_lanes_aligned_r4: assert property (@(posedge clk) disable iff (rst)
    fmt_q == FMT_DUAL4 |-> need_a == need_b);

  // R9: the latched mode only changes under reset
  p_mode_static_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(fmt_q));
endmodule

// File: tb/gbx_serializer_test.sv
`timescale 1ns/1ps
module gbx_serializer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       d_valid = 1'b0;
  logic [7:0] d = 8'h00;
  logic       d_ready, q_a_rise, q_a_fall, q_b_rise, q_b_fall;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int e_start = 0;
  bit mon_on = 1'b0;
  bit dual = 1'b0;
  bit saw_block = 1'b0;
  string tag = "R2";
  bit qa[$];
  bit qb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gbx_serializer uut (
    .clk(clk), .rst(rst), .mode(mode), .d_valid(d_valid), .d_ready(d_ready),
    .d(d), .q_a_rise(q_a_rise), .q_a_fall(q_a_fall),
    .q_b_rise(q_b_rise), .q_b_fall(q_b_fall)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic bit pop_a();
    if (qa.size() > 0) return qa.pop_front();
    return 1'b0;
  endfunction

  function automatic bit pop_b();
    if (qb.size() > 0) return qb.pop_front();
    return 1'b0;
  endfunction

  // monitor: one bit pair per lane per cycle once the first word is due
  always @(negedge clk) begin
    if (mon_on && cyc >= e_start + 2) begin
      logic [3:0] ex;
      ex[0] = pop_a();
      ex[1] = pop_a();
      if (dual) begin
        ex[2] = pop_b();
        ex[3] = pop_b();
      end else begin
        ex[3:2] = 2'b00; // R5
      end
      check(tag, {q_b_fall, q_b_rise, q_a_fall, q_a_rise}, ex);
    end
  end

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    mon_on = 1'b0;
    d_valid = 1'b0;
    qa.delete();
    qb.delete();
    mode = m;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1: idle after reset, ready, outputs low
    check("R1", {q_b_fall, q_b_rise, q_a_fall, q_a_rise}, 4'b0000);
    check("R1", {3'b000, d_ready}, 4'b0001);
  endtask

  task automatic send_burst(input int nw, input logic [1:0] m, input int flip_at);
    int acc = 0;
    saw_block = 1'b0;
    while (acc < nw) begin
      d_valid = 1'b1;
      d = 8'h80 ^ 8'(acc * 37 + 5) ^ 8'(m * 91);
      if (m == 2'b01) d[7] = 1'b1; // R3: bit 7 set, must not appear
      if (d_ready) begin
        if (acc == 0) begin
          e_start = cyc + 1;
          mon_on = 1'b1;
        end
        if (m == 2'b10) begin
          for (int i = 0; i < 4; i++) qa.push_back(d[i]);
          for (int i = 4; i < 8; i++) qb.push_back(d[i]);
        end else begin
          for (int i = 0; i < ((m == 2'b01) ? 7 : 8); i++) qa.push_back(d[i]);
        end
        acc++;
        if (acc == flip_at) mode = 2'b10; // R9: change ignored while running
      end else begin
        saw_block = 1'b1;
      end
      @(negedge clk);
    end
    d_valid = 1'b0;
    // R8: drain, then zeros are expected from the empty queues
    while (qa.size() > 0 || qb.size() > 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // 8:1 with a mid-burst mode pin change
    dual = 1'b0;
    tag = "R2/R6/R9";
    do_reset(2'b00);
    send_burst(12, 2'b00, 5);
    check("R7", {3'b000, saw_block}, 4'b0001); // back-pressure seen in 8:1

    // 7:1, bit 7 set in every word
    tag = "R3/R8";
    do_reset(2'b01);
    send_burst(11, 2'b01, 0);

    // dual 4:1
    dual = 1'b1;
    tag = "R4/R7";
    do_reset(2'b10);
    send_burst(14, 2'b10, 0);

    // code 11 behaves as 8:1, lane B idle
    dual = 1'b0;
    tag = "R5";
    do_reset(2'b11);
    send_burst(6, 2'b11, 0);

    mon_on = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule